// File: doc/BRIEF.md
# Virtual Framebuffer Address Translator

This block maps a byte address inside one of several virtual framebuffers onto a physical memory address. Each virtual framebuffer is a stack of lines. A translation table holds one entry per line, and that entry says which 16-byte blocks of the line are backed by memory. A line may be turned off entirely. If it is on, only the blocks from its first valid block to its last valid block, both inclusive, are mapped. Each entry also carries a line offset that places block 0 of the line in physical memory.

A request names a buffer and a virtual byte address. The split of the address into line, block and byte depends on a mode bit. With the bit at 0, a line holds 256 blocks. With the bit at 1, a line holds 192 blocks, which is 3072 bytes. A mapped request returns a physical address built from the buffer's base and offset, the line offset and the block position. An unmapped request returns no address. It returns a programmable default word instead, and no memory access should follow it.

A word-wide register port sets up the block. Through it software programs the mode, the per-buffer interrupt enables, the default word, each buffer's base and offset, and the table entries. The same port reads back the per-buffer overflow flags, and software clears those flags by writing 1s.

Top module: `vfb_translator`

## Requirements
- R1: After a synchronous reset, out_valid, out_hit, irq and every overflow flag are 0, in_ready is 1, and the status word reads 0.
- R2: With the mode bit (bit 8 of control word 0) at 0, the line is vaddr[21:12], the block is vaddr[11:4] and the byte is vaddr[3:0]. A mapped result has out_hit=1 and out_paddr = {base, S[22:0]}, where S = 16*buffer offset + 16*line offset + 16*block + byte.
- R3: With the mode bit at 1, the line is vaddr/3072 and the block is (vaddr mod 3072)/16. A line number of 1024 or above is unmapped.
- R4: A request is unmapped when the line's enable (bit 31 of the table low word) is 0, or when its block is below the first valid block (bits 7:0) or above the last valid block (bits 15:8). An unmapped result has out_hit=0 and out_paddr=0, and out_dflt equals the default word (register 3). A mapped result has out_dflt=0.
- R5: A request is accepted on a clock edge where in_valid and in_ready are both 1, and its result shows on the outputs after that same edge. in_ready is 1 when out_valid is 0 or out_ready is 1. While out_valid=1 and out_ready=0, the result outputs hold their values and no new request is accepted.
- R6: When a mapped request's 24-bit sum S has bit 23 set, the overflow flag of its buffer is set. out_paddr still carries S[22:0].
- R7: Writing register 2 clears each overflow flag whose data bit is 1. A data bit of 0 leaves its flag unchanged. Status register 1 shows the flags in bits 3:0.
- R8: irq is 1 exactly when some overflow flag and its enable bit (control word 0, bits 3:0) are both 1.
- R9: A register read returns, one cycle after the address is presented, the control word, the default word, or a buffer word. Buffer words are registers 4 to 7 and hold the base in bits 31:23 and the offset in bits 18:0. Table words sit at address {1, line, 0} for the low word and {1, line, 1} for the high word, and the high word holds the line offset in bits 17:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_buf | input | 2 | Buffer index of request |
| in_vaddr | input | 22 | Virtual byte address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed |
| out_hit | output | 1 | 1 if location is mapped |
| out_paddr | output | 32 | Physical address (0 when unmapped) |
| out_dflt | output | 32 | Default word when unmapped, else 0 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Enabled overflow interrupt |

## Verification
The bench builds the block with its default parameters: four buffers, 1024 lines, 8-bit block fields, a 22-bit virtual address and 19-bit buffer offsets. With these values, the last table line (1023) and the top block of a 256-block line are reachable with one address. A buffer offset near the top of its range pushes the 23-bit sum into a carry, so the overflow path fires after a single request. A 192-block address that lands on line 1024 exercises the out-of-range line case.

// File: rtl/vfb_pkg.sv
package vfb_pkg;
  localparam int DATA_W = 32;
  localparam int RG_CTRL = 0;
  localparam int RG_STAT = 1;
  localparam int RG_CLR  = 2;
  localparam int RG_DFLT = 3;
  localparam int RG_BUF0 = 4;
  localparam int CTRL_MODE_BIT = 8;
  localparam int LUT_EN_BIT = 31;

  typedef enum logic {
    MODE_256 = 1'b0,
    MODE_192 = 1'b1
  } blk_mode_e;
endpackage

// File: rtl/vfb_addr_split.sv
module vfb_addr_split
  import vfb_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int BLK_W  = 8,
  parameter int BYTE_W = 4,
  parameter int VA_W   = LINE_W + BLK_W + BYTE_W
) (
  input  logic [VA_W-1:0]   vaddr,
  input  blk_mode_e         mode,
  output logic [LINE_W-1:0] line,
  output logic              line_oob,
  output logic [BLK_W-1:0]  blk,
  output logic [BYTE_W-1:0] byte_ofs
);
  // a 3/4 line is three quarter-line chunks of 2^KSH bytes
  localparam int LOG_LB = BLK_W + BYTE_W;
  localparam int KSH    = LOG_LB - 2;
  localparam int KW     = VA_W - KSH;

  logic [KW-1:0]     chunk;
  logic [KW-1:0]     quot;
  logic [1:0]        rem;
  logic [LOG_LB-1:0] in_line;

  always_comb begin
    chunk   = vaddr[VA_W-1:KSH];
    quot    = chunk / KW'(3);
    rem     = 2'(chunk % KW'(3));
    in_line = {rem, vaddr[KSH-1:0]};
    if (mode == MODE_192) begin
      line     = quot[LINE_W-1:0];
      line_oob = |quot[KW-1:LINE_W];
      blk      = in_line[LOG_LB-1:BYTE_W];
      byte_ofs = in_line[BYTE_W-1:0];
    end else begin
      line     = vaddr[VA_W-1 -: LINE_W];
      line_oob = 1'b0;
      blk      = vaddr[BYTE_W +: BLK_W];
      byte_ofs = vaddr[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/vfb_lut.sv
module vfb_lut #(
  parameter int LINE_W = 10,
  parameter int BLK_W  = 8,
  parameter int LOFF_W = 18
) (
  input  logic                 clk,
  input  logic                 we_lo,
  input  logic                 we_hi,
  input  logic [LINE_W-1:0]    widx,
  input  logic [2*BLK_W:0]     wlo,
  input  logic [LOFF_W-1:0]    whi,
  input  logic [LINE_W-1:0]    ridx,
  output logic                 en,
  output logic [BLK_W-1:0]     first,
  output logic [BLK_W-1:0]     last,
  output logic [LOFF_W-1:0]    loff
);
  localparam int DEPTH = 1 << LINE_W;

  logic [2*BLK_W:0]  mem_lo [DEPTH];
  logic [LOFF_W-1:0] mem_hi [DEPTH];

  always_ff @(posedge clk) begin
    if (we_lo) mem_lo[widx] <= wlo;
  end

  always_ff @(posedge clk) begin
    if (we_hi) mem_hi[widx] <= whi;
  end

  always_comb begin
    {en, last, first} = mem_lo[ridx];
    loff              = mem_hi[ridx];
  end
endmodule

// File: rtl/vfb_xlate.sv
module vfb_xlate #(
  parameter int BLK_W  = 8,
  parameter int BYTE_W = 4,
  parameter int LOFF_W = 18,
  parameter int BOFF_W = 19,
  parameter int BASE_W = 9,
  parameter int PA_W   = BASE_W + BOFF_W + BYTE_W
) (
  input  logic              line_oob,
  input  logic [BLK_W-1:0]  blk,
  input  logic [BYTE_W-1:0] byte_ofs,
  input  logic              en,
  input  logic [BLK_W-1:0]  first,
  input  logic [BLK_W-1:0]  last,
  input  logic [LOFF_W-1:0] loff,
  input  logic [BOFF_W-1:0] boff,
  input  logic [BASE_W-1:0] base,
  output logic              hit,
  output logic              carry,
  output logic [PA_W-1:0]   paddr
);
  localparam int SUM_W = BOFF_W + BYTE_W;
  localparam int SW    = SUM_W + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum = {1'b0, boff, {BYTE_W{1'b0}}}
        + SW'({loff, {BYTE_W{1'b0}}})
        + SW'({blk, {BYTE_W{1'b0}}})
        + SW'(byte_ofs);
    hit   = en && !line_oob && (blk >= first) && (blk <= last);
    carry = sum[SW-1];
    paddr = hit ? {base, sum[SUM_W-1:0]} : '0;
  end
endmodule

// File: rtl/vfb_regs.sv
module vfb_regs
  import vfb_pkg::*;
#(
  parameter int N_BUF  = 4,
  parameter int LINE_W = 10,
  parameter int BLK_W  = 8,
  parameter int LOFF_W = 18,
  parameter int BOFF_W = 19,
  parameter int BASE_W = 9,
  parameter int REG_AW = LINE_W + 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_we,
  input  logic [REG_AW-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  input  logic [N_BUF-1:0]               ovf_set,
  output blk_mode_e                      mode,
  output logic [N_BUF-1:0]               irq_en,
  output logic [N_BUF-1:0]               ovf_flags,
  output logic [DATA_W-1:0]              dflt,
  output logic [N_BUF-1:0][BASE_W-1:0]   buf_base,
  output logic [N_BUF-1:0][BOFF_W-1:0]   buf_off,
  output logic                           lut_we_lo,
  output logic                           lut_we_hi,
  output logic [LINE_W-1:0]              lut_widx,
  output logic [2*BLK_W:0]               lut_wlo,
  output logic [LOFF_W-1:0]              lut_whi
);
  localparam int PAD = DATA_W - BASE_W - BOFF_W;

  logic              in_lut;
  logic [DATA_W-1:0] rd_next;

  assign in_lut    = reg_addr[REG_AW-1];
  assign lut_we_lo = reg_we && in_lut && !reg_addr[0];
  assign lut_we_hi = reg_we && in_lut && reg_addr[0];
  assign lut_widx  = reg_addr[LINE_W:1];
  assign lut_wlo   = {reg_wdata[LUT_EN_BIT], reg_wdata[2*BLK_W-1:0]};
  assign lut_whi   = reg_wdata[LOFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_256;
      irq_en <= '0;
      dflt   <= '0;
    end else if (reg_we && reg_addr == REG_AW'(RG_CTRL)) begin
      mode   <= blk_mode_e'(reg_wdata[CTRL_MODE_BIT]);
      irq_en <= reg_wdata[N_BUF-1:0];
    end else if (reg_we && reg_addr == REG_AW'(RG_DFLT)) begin
      dflt   <= reg_wdata;
    end
  end

  for (genvar i = 0; i < N_BUF; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst) begin
        buf_base[i] <= '0;
        buf_off[i]  <= '0;
      end else if (reg_we && reg_addr == REG_AW'(RG_BUF0 + i)) begin
        buf_base[i] <= reg_wdata[DATA_W-1 -: BASE_W];
        buf_off[i]  <= reg_wdata[BOFF_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)
        ovf_flags[i] <= 1'b0;
      else if (ovf_set[i])
        ovf_flags[i] <= 1'b1;
      else if (reg_we && reg_addr == REG_AW'(RG_CLR) && reg_wdata[i])
        ovf_flags[i] <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    if (reg_addr == REG_AW'(RG_CTRL))
      rd_next = DATA_W'(irq_en) | (DATA_W'(mode) << CTRL_MODE_BIT);
    else if (reg_addr == REG_AW'(RG_STAT))
      rd_next = DATA_W'(ovf_flags);
    else if (reg_addr == REG_AW'(RG_DFLT))
      rd_next = dflt;
    for (int i = 0; i < N_BUF; i++)
      if (reg_addr == REG_AW'(RG_BUF0 + i))
        rd_next = {buf_base[i], {PAD{1'b0}}, buf_off[i]};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/vfb_translator.sv
module vfb_translator
  import vfb_pkg::*;
#(
  parameter int N_BUF  = 4,
  parameter int LINE_W = 10,
  parameter int BLK_W  = 8,
  parameter int BYTE_W = 4,
  parameter int LOFF_W = 18,
  parameter int BOFF_W = 19,
  parameter int BASE_W = 9,
  localparam int BUF_W  = $clog2(N_BUF),
  localparam int VA_W   = LINE_W + BLK_W + BYTE_W,
  localparam int PA_W   = BASE_W + BOFF_W + BYTE_W,
  localparam int REG_AW = LINE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BUF_W-1:0]  in_buf,
  input  logic [VA_W-1:0]   in_vaddr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [PA_W-1:0]   out_paddr,
  output logic [DATA_W-1:0] out_dflt,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  blk_mode_e                     mode;
  logic [N_BUF-1:0]              irq_en;
  logic [N_BUF-1:0]              ovf_flags;
  logic [N_BUF-1:0]              ovf_set;
  logic [DATA_W-1:0]             dflt;
  logic [N_BUF-1:0][BASE_W-1:0]  buf_base;
  logic [N_BUF-1:0][BOFF_W-1:0]  buf_off;
  logic                          lut_we_lo, lut_we_hi;
  logic [LINE_W-1:0]             lut_widx;
  logic [2*BLK_W:0]              lut_wlo;
  logic [LOFF_W-1:0]             lut_whi;

  logic [LINE_W-1:0] line;
  logic              line_oob;
  logic [BLK_W-1:0]  blk;
  logic [BYTE_W-1:0] byte_ofs;
  logic              ln_en;
  logic [BLK_W-1:0]  ln_first, ln_last;
  logic [LOFF_W-1:0] ln_loff;
  logic              hit, carry, accept;
  logic [PA_W-1:0]   paddr;

  vfb_regs #(
    .N_BUF(N_BUF), .LINE_W(LINE_W), .BLK_W(BLK_W), .LOFF_W(LOFF_W),
    .BOFF_W(BOFF_W), .BASE_W(BASE_W), .REG_AW(REG_AW)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_set(ovf_set),
    .mode(mode), .irq_en(irq_en), .ovf_flags(ovf_flags), .dflt(dflt),
    .buf_base(buf_base), .buf_off(buf_off), .lut_we_lo(lut_we_lo),
    .lut_we_hi(lut_we_hi), .lut_widx(lut_widx), .lut_wlo(lut_wlo),
    .lut_whi(lut_whi)
  );

  vfb_addr_split #(
    .LINE_W(LINE_W), .BLK_W(BLK_W), .BYTE_W(BYTE_W), .VA_W(VA_W)
  ) u_split (
    .vaddr(in_vaddr), .mode(mode), .line(line), .line_oob(line_oob),
    .blk(blk), .byte_ofs(byte_ofs)
  );

  vfb_lut #(
    .LINE_W(LINE_W), .BLK_W(BLK_W), .LOFF_W(LOFF_W)
  ) u_lut (
    .clk(clk), .we_lo(lut_we_lo), .we_hi(lut_we_hi), .widx(lut_widx),
    .wlo(lut_wlo), .whi(lut_whi), .ridx(line), .en(ln_en),
    .first(ln_first), .last(ln_last), .loff(ln_loff)
  );

  vfb_xlate #(
    .BLK_W(BLK_W), .BYTE_W(BYTE_W), .LOFF_W(LOFF_W), .BOFF_W(BOFF_W),
    .BASE_W(BASE_W), .PA_W(PA_W)
  ) u_xlate (
    .line_oob(line_oob), .blk(blk), .byte_ofs(byte_ofs), .en(ln_en),
    .first(ln_first), .last(ln_last), .loff(ln_loff),
    .boff(buf_off[in_buf]), .base(buf_base[in_buf]),
    .hit(hit), .carry(carry), .paddr(paddr)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign irq      = |(ovf_flags & irq_en);

  for (genvar i = 0; i < N_BUF; i++) begin : g_ovf
    assign ovf_set[i] = accept && hit && carry && (in_buf == BUF_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_paddr <= '0;
      out_dflt  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_hit   <= hit;
      out_paddr <= paddr;
      out_dflt  <= hit ? '0 : dflt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vfb_translator_chk.sv
module vfb_translator_chk
  import vfb_pkg::*;
#(
  parameter int N_BUF  = 4,
  parameter int LINE_W = 10,
  parameter int PA_W   = 32,
  localparam int REG_AW = LINE_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic [PA_W-1:0]   out_paddr,
  input logic              irq,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [N_BUF-1:0]  flags,
  input logic [N_BUF-1:0]  ie
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !irq && flags == '0));

  p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (out_paddr == '0));

  p_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_hit) && $stable(out_paddr)));

  p_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (ie == '0) |-> !irq);

  for (genvar i = 0; i < N_BUF; i++) begin : g_flag
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !(reg_we && reg_addr == REG_AW'(RG_CLR) && reg_wdata[i]))
        |=> flags[i]);
  end
endmodule

bind vfb_translator vfb_translator_chk #(
  .N_BUF(N_BUF), .LINE_W(LINE_W), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
  .out_paddr(out_paddr), .irq(irq), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .flags(ovf_flags), .ie(irq_en)
);

// File: tb/sim_vfb_translator.sv
`timescale 1ns/1ps
module sim_vfb_translator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_buf = '0;
  logic [21:0] in_vaddr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_hit;
  logic [31:0] out_paddr;
  logic [31:0] out_dflt;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  localparam logic [31:0] DFLT = 32'hDEAD_BEEF;

  // {mode, buf, vaddr, hit, paddr}
  localparam logic [57:0] VEC [12] = '{
    {1'b0, 2'd0, 22'h000123, 1'b1, 32'h6000_1123},
    {1'b0, 2'd0, 22'h001040, 1'b1, 32'h6000_1140},
    {1'b0, 2'd0, 22'h0010AF, 1'b1, 32'h6000_11AF},
    {1'b0, 2'd0, 22'h001030, 1'b0, 32'h0000_0000},
    {1'b0, 2'd0, 22'h0010B0, 1'b0, 32'h0000_0000},
    {1'b0, 2'd0, 22'h002000, 1'b0, 32'h0000_0000},
    {1'b0, 2'd2, 22'h3FFFFF, 1'b1, 32'h0040_0FEF},
    {1'b0, 2'd1, 22'h000200, 1'b1, 32'h0080_0100},
    {1'b1, 2'd0, 22'h0047F7, 1'b1, 32'h6000_3BF7},
    {1'b1, 2'd0, 22'h000C40, 1'b1, 32'h6000_1140},
    {1'b1, 2'd0, 22'h000CB0, 1'b0, 32'h0000_0000},
    {1'b1, 2'd0, 22'h300000, 1'b0, 32'h0000_0000}
  };

  vfb_translator u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_buf(in_buf), .in_vaddr(in_vaddr), .out_valid(out_valid),
    .out_ready(out_ready), .out_hit(out_hit), .out_paddr(out_paddr),
    .out_dflt(out_dflt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic lut(input logic [9:0] idx, input logic en, input logic [7:0] f,
                     input logic [7:0] l, input logic [17:0] lo);
    wr({1'b1, idx, 1'b0}, {en, 15'b0, l, f});
    wr({1'b1, idx, 1'b1}, {14'b0, lo});
  endtask

  task automatic req(input logic [1:0] b, input logic [21:0] va);
    in_valid = 1'b1; in_buf = b; in_vaddr = va;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        cur_mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    rd(12'd1, d);
    chk("R1 status", d, 0);

    wr(12'd3, DFLT);
    wr(12'd4, {9'h0C0, 4'b0, 19'h00100});
    wr(12'd5, {9'h001, 4'b0, 19'h7FFF0});
    wr(12'd6, 32'h0);
    lut(10'd0, 1'b1, 8'd0, 8'd255, 18'h0);
    lut(10'd1, 1'b1, 8'd4, 8'd10, 18'h00010);
    lut(10'd2, 1'b0, 8'd0, 8'd255, 18'h0);
    lut(10'd5, 1'b1, 8'd0, 8'd191, 18'h00200);
    lut(10'd1023, 1'b1, 8'd0, 8'd255, 18'h3FFFF);

    // R9 readback
    rd(12'd3, d);
    chk("R9 default word", d, DFLT);
    rd(12'd4, d);
    chk("R9 buffer word", d, 32'h6000_0100);

    // R2 R3 R4 R6 table walk
    cur_mode = 1'b0;
    for (int k = 0; k < 12; k++) begin
      logic [57:0] v;
      v = VEC[k];
      if (v[57] != cur_mode) begin
        wr(12'd0, {23'b0, v[57], 8'b0});
        cur_mode = v[57];
      end
      req(v[56:55], v[54:33]);
      chk($sformatf("R2/R3/R4 vec%0d valid", k), 32'(out_valid), 1);
      chk($sformatf("R2/R3/R4 vec%0d hit", k), 32'(out_hit), 32'(v[32]));
      chk($sformatf("R2/R3/R4 vec%0d paddr", k), out_paddr, v[31:0]);
      chk($sformatf("R4 vec%0d dflt", k), out_dflt, v[32] ? 32'h0 : DFLT);
    end
    rd(12'd0, d);
    chk("R9 control word", d, 32'h0000_0100);

    // R6 overflow from vector 7 on buffer 1
    rd(12'd1, d);
    chk("R6 status after carry", d, 32'h2);
    chk("R8 irq masked", 32'(irq), 0);
    wr(12'd0, {23'b0, 1'b1, 4'b0, 4'b0010});
    chk("R8 irq enabled", 32'(irq), 1);
    wr(12'd2, 32'h0);
    rd(12'd1, d);
    chk("R7 write zero keeps flag", d, 32'h2);
    wr(12'd2, 32'h2);
    rd(12'd1, d);
    chk("R7 write one clears", d, 32'h0);
    chk("R8 irq after clear", 32'(irq), 0);

    // R5 backpressure (mode 192)
    out_ready = 1'b0;
    in_valid = 1'b1; in_buf = 2'd0; in_vaddr = 22'h000C40;
    @(posedge clk); @(negedge clk);
    chk("R5 first result", out_paddr, 32'h6000_1140);
    chk("R5 in_ready low", 32'(in_ready), 0);
    in_vaddr = 22'h0047F7;
    @(posedge clk); @(negedge clk);
    chk("R5 held result", out_paddr, 32'h6000_1140);
    chk("R5 still valid", 32'(out_valid), 1);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R5 second result", out_paddr, 32'h6000_3BF7);
    chk("R5 second valid", 32'(out_valid), 1);
    @(posedge clk); @(negedge clk);
    chk("R5 drained", 32'(out_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule